// File: doc/BRIEF.md
# Challenge Trigger and Status Display Controller

This block decides when an authentication run should begin and shows its outcome on two active-low open-drain status pins. It watches a challenge strobe whose active sense is chosen by a configuration bit. The strobe is read once as a level after a power-up delay, and after that as insertion and removal edges. Bus presence events reported by a separate bus master can also start a run, and an optional poll timer asks that master for a bus reset at a fixed interval so that a token's arrival or departure is noticed.

The sequencer that runs the exchange with the token is outside this block. It receives a one-cycle `start` pulse and answers with `seq_busy`, then a one-cycle `seq_done` carrying `seq_pass`. The status pins are modelled as pull-down enables: a 1 on `pass_low` or `fail_low` means that pin is pulled low, and a 0 means it is left high-impedance. FAIL can either stay low or blink with a 50 % duty cycle.

Top module: `auth_trigger_ctrl`

## Requirements
- R1: The strobe passes through two synchroniser flops and a filter. A change that lasts fewer than `DEB_CYC` consecutive clock cycles after synchronisation has no effect on `start`, `pass_low` or `fail_low`.
- R2: When `cfg_pol`=0, a low strobe means present, a falling edge is an insertion and a rising edge is a removal. When `cfg_pol`=1, all three senses are inverted.
- R3: `PU_DLY` cycles after reset is released, the filtered strobe level is sampled once. If it shows presence, exactly one `start` pulse follows. A strobe already present before that sample is not treated as an insertion.
- R4: After that sample, a filtered insertion edge produces a `start` pulse. A filtered removal edge sets both `pass_low` and `fail_low` to 0.
- R5: Both status outputs are 0 during reset, while armed, and from a `start` pulse until `seq_done`. On `seq_done`, only `pass_low` (when `seq_pass`=1) or only FAIL (when `seq_pass`=0) becomes active. Both outputs are never 1 together.
- R6: With `cfg_blink`=0, `fail_low` stays at 1 while FAIL is shown. With `cfg_blink`=1, it is 1 for `BLINK_HALF` cycles and then 0 for `BLINK_HALF` cycles, repeating, starting with the 1 phase.
- R7: With `cfg_bus_det`=1, a `bus_insert` pulse starts authentication.
- R8: With `cfg_poll_en`=1 and no run in progress, `poll_req` pulses once every `POLL_PERIOD` cycles. A `poll_done` with `poll_present`=1 while nothing is shown starts authentication. A `poll_done` with `poll_present`=0 sets both status outputs to 0.
- R9: A trigger that arrives while a run is in progress (from `start` until `seq_done`) or while `seq_busy` is 1 causes no extra `start`.
- R10: `start` and `poll_req` are each high for exactly one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chal_in | input | 1 | Challenge strobe (asynchronous) |
| cfg_pol | input | 1 | Strobe sense: 0 = low means present, 1 = high means present |
| cfg_blink | input | 1 | 1 = FAIL blinks, 0 = FAIL is held low |
| cfg_bus_det | input | 1 | 1 = bus insertion events start a run |
| cfg_poll_en | input | 1 | 1 = periodic bus polling enabled |
| bus_insert | input | 1 | Pulse from the bus master: an unsolicited presence pulse was seen |
| poll_done | input | 1 | Pulse from the bus master: the requested poll reset has finished |
| poll_present | input | 1 | Poll result, valid with `poll_done` |
| seq_busy | input | 1 | Sequencer is running |
| seq_done | input | 1 | Sequencer finished (one-cycle pulse) |
| seq_pass | input | 1 | Result of the run, valid with `seq_done` |
| start | output | 1 | One-cycle request to begin authentication |
| poll_req | output | 1 | One-cycle request for a bus reset and presence check |
| pass_low | output | 1 | 1 = PASS pin pulled low, 0 = high-impedance |
| fail_low | output | 1 | 1 = FAIL pin pulled low, 0 = high-impedance |

## Verification
The assertions check four properties on every cycle: PASS and FAIL are never active together, both pins are released when a `start` pulse appears, PASS can only appear right after a passing `seq_done`, and `start` and `poll_req` last one cycle each. Only the bench's scenarios can show the behaviours that depend on history. These are the strobe filter rejecting short glitches, the sense inversion across both polarities, the single power-up sample, the blink duty and period, the poll interval and its effect on the display, and triggers being dropped while a run is in progress. The bench sweeps every combination of polarity, fail mode and result.

// File: rtl/auth_trigger_ctrl.sv
module auth_trigger_ctrl #(
  parameter int PU_DLY      = 6_500_000,
  parameter int DEB_CYC     = 1000,
  parameter int BLINK_HALF  = 25_000_000,
  parameter int POLL_PERIOD = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chal_in,
  input  logic cfg_pol,
  input  logic cfg_blink,
  input  logic cfg_bus_det,
  input  logic cfg_poll_en,
  input  logic bus_insert,
  input  logic poll_done,
  input  logic poll_present,
  input  logic seq_busy,
  input  logic seq_done,
  input  logic seq_pass,
  output logic start,
  output logic poll_req,
  output logic pass_low,
  output logic fail_low
);
  localparam int PUW = $clog2(PU_DLY + 1);
  localparam int DW  = $clog2(DEB_CYC + 1);
  localparam int BW  = $clog2(BLINK_HALF + 1);
  localparam int PW  = $clog2(POLL_PERIOD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PASS, ST_FAIL} st_t;

  st_t            st;
  logic [1:0]     sync;
  logic           chal_f;
  logic [DW-1:0]  dcnt;
  logic [PUW-1:0] pcnt;
  logic           pu_done;
  logic [BW-1:0]  bcnt;
  logic           bph;
  logic [PW-1:0]  qcnt;

  wire diff     = sync[1] ^ chal_f;
  wire flip     = diff && (dcnt == DW'(DEB_CYC - 1));
  wire now_pres = (sync[1] == cfg_pol);
  wire ins_edge = flip && pu_done && now_pres;
  wire rem_edge = flip && pu_done && !now_pres;
  wire pu_hit   = !pu_done && (pcnt == PUW'(PU_DLY - 1));
  wire pu_trig  = pu_hit && (chal_f == cfg_pol);
  wire poll_ok  = poll_done && (st != ST_RUN);
  wire trig     = pu_trig || ins_edge || (cfg_bus_det && bus_insert)
                  || (poll_ok && poll_present && st == ST_IDLE);
  wire clr      = rem_edge || (poll_ok && !poll_present);
  wire go       = trig && (st != ST_RUN) && !seq_busy && !clr;
  wire polling  = cfg_poll_en && (st != ST_RUN) && !seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= {2{~cfg_pol}};
      chal_f <= ~cfg_pol;
      dcnt   <= '0;
    end else begin
      sync <= {sync[0], chal_in};
      if (!diff) dcnt <= '0;
      else if (flip) begin
        chal_f <= sync[1];
        dcnt   <= '0;
      end else dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      pu_done <= 1'b0;
    end else if (!pu_done) begin
      pcnt <= pcnt + 1'b1;
      if (pu_hit) pu_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      start <= 1'b0;
    end else begin
      start <= go;
      if (go) st <= ST_RUN;
      else if (clr) st <= ST_IDLE;
      else if (st == ST_RUN && seq_done) st <= seq_pass ? ST_PASS : ST_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      bph  <= 1'b1;
    end else if (st != ST_FAIL) begin
      bcnt <= '0;
      bph  <= 1'b1;
    end else if (bcnt == BW'(BLINK_HALF - 1)) begin
      bcnt <= '0;
      bph  <= ~bph;
    end else bcnt <= bcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt     <= '0;
      poll_req <= 1'b0;
    end else if (!polling) begin
      qcnt     <= '0;
      poll_req <= 1'b0;
    end else if (qcnt == PW'(POLL_PERIOD - 1)) begin
      qcnt     <= '0;
      poll_req <= 1'b1;
    end else begin
      qcnt     <= qcnt + 1'b1;
      poll_req <= 1'b0;
    end
  end

  assign pass_low = (st == ST_PASS);
  assign fail_low = (st == ST_FAIL) && (!cfg_blink || bph);
endmodule

// File: rtl/auth_trigger_ctrl_chk.sv
module auth_trigger_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic poll_req,
  input logic seq_done,
  input logic seq_pass,
  input logic pass_low,
  input logic fail_low
);
  // R5
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_low && fail_low));

  // R5
  start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!pass_low && !fail_low));

  // R5
  pass_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_low) |-> $past(seq_done && seq_pass));

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R10
  poll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> !poll_req);
endmodule

bind auth_trigger_ctrl auth_trigger_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .poll_req(poll_req),
  .seq_done(seq_done), .seq_pass(seq_pass),
  .pass_low(pass_low), .fail_low(fail_low)
);

// File: tb/auth_trigger_ctrl_tb.sv
`timescale 1ns/1ps
module auth_trigger_ctrl_tb;
  localparam int PU = 40, DEB = 4, HALF = 8, POLL = 50, LAT = 10;

  logic clk = 0, rst_n = 0, chal_in = 1;
  logic cfg_pol = 0, cfg_blink = 0, cfg_bus_det = 1, cfg_poll_en = 0;
  logic bus_insert = 0, poll_done = 0, poll_present = 0;
  logic seq_busy, seq_done, seq_pass;
  logic start, poll_req, pass_low, fail_low;
  logic tb_pass = 1;
  int vecs = 0, errs = 0, starts = 0, start_hi = 0, left = 0;
  logic start_d = 0;

  always #5 clk = ~clk;

  auth_trigger_ctrl #(.PU_DLY(PU), .DEB_CYC(DEB), .BLINK_HALF(HALF), .POLL_PERIOD(POLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .chal_in(chal_in), .cfg_pol(cfg_pol), .cfg_blink(cfg_blink),
    .cfg_bus_det(cfg_bus_det), .cfg_poll_en(cfg_poll_en), .bus_insert(bus_insert),
    .poll_done(poll_done), .poll_present(poll_present), .seq_busy(seq_busy),
    .seq_done(seq_done), .seq_pass(seq_pass), .start(start), .poll_req(poll_req),
    .pass_low(pass_low), .fail_low(fail_low));

  initial begin
    seq_busy = 0; seq_done = 0; seq_pass = 0;
    forever begin
      @(negedge clk);
      seq_done = 0;
      if (start) begin
        if (!start_d) starts++;
        start_hi++;
      end
      start_d = start;
      if (seq_busy) begin
        left--;
        if (left == 0) begin seq_busy = 0; seq_done = 1; seq_pass = tb_pass; end
      end else if (start) begin
        seq_busy = 1; left = LAT;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fail_count(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); hi += fail_low; end
  endtask

  task automatic check_result(input string tag, input logic blink, input logic res);
    int hi;
    if (res) begin
      chk({tag, " pass_low"}, pass_low, 1);
      chk({tag, " fail_low"}, fail_low, 0);
    end else begin
      chk({tag, " pass_low"}, pass_low, 0);
      fail_count(4 * HALF, hi);
      chk({tag, " R6 fail duty"}, hi, blink ? 2 * HALF : 4 * HALF);
    end
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int hi, n;
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 2; r++) begin
          cfg_pol = p[0]; cfg_blink = b[0]; tb_pass = r[0];
          cfg_bus_det = 1; cfg_poll_en = 0;
          chal_in = cfg_pol;                       // present level
          rst_n = 0; tick(3);
          chk("R5 reset pass_low", pass_low, 0);
          chk("R5 reset fail_low", fail_low, 0);
          chk("R10 reset start", start, 0);
          starts = 0; start_hi = 0;
          rst_n = 1;
          tick(PU - 3);
          chk("R3 no start before delay", starts, 0);
          tick(6);
          chk("R3 power-up start", starts, 1);
          chk("R5 released while running", pass_low | fail_low, 0);
          bus_insert = 1; tick(1); bus_insert = 0;   // R9 trigger while busy
          tick(18);
          chk("R9 trigger while busy ignored", starts, 1);
          check_result("R5 R3", cfg_blink, tb_pass);
          chal_in = ~cfg_pol; tick(2); chal_in = cfg_pol;  // R1 short glitch
          tick(10);
          check_result("R1 glitch ignored", cfg_blink, tb_pass);
          chk("R1 no start on glitch", starts, 1);
          chal_in = ~cfg_pol;                      // removal
          tick(2 + DEB + 3);
          chk("R4 R2 removal pass_low", pass_low, 0);
          fail_count(2 * HALF, hi);
          chk("R4 R2 removal fail_low", hi, 0);
          chal_in = cfg_pol;                       // insertion
          tick(2 + DEB + 3);
          chk("R4 R2 insertion start", starts, 2);
          tick(20);
          check_result("R4 second run", cfg_blink, tb_pass);
          bus_insert = 1; tick(1); bus_insert = 0;
          tick(4);
          chk("R7 bus insert start", starts, 3);
          tick(20);
          check_result("R7 result", cfg_blink, tb_pass);
          chk("R10 start one cycle", start_hi, starts);
        end

    cfg_pol = 0; cfg_blink = 0; cfg_bus_det = 0; cfg_poll_en = 1; tb_pass = 1;
    chal_in = 1;
    rst_n = 0; tick(3); starts = 0; start_hi = 0; rst_n = 1;
    while (!poll_req) @(negedge clk);
    chk("R3 absent at power-up no start", starts, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!poll_req);
    chk("R8 poll interval", n, POLL);
    poll_present = 1; poll_done = 1; tick(1); poll_done = 0;
    tick(3);
    chk("R8 poll presence start", starts, 1);
    tick(20);
    chk("R8 poll run pass_low", pass_low, 1);
    while (!poll_req) @(negedge clk);
    poll_present = 1; poll_done = 1; tick(1); poll_done = 0;
    tick(3);
    chk("R8 present while shown no restart", starts, 1);
    chk("R8 display kept", pass_low, 1);
    while (!poll_req) @(negedge clk);
    poll_present = 0; poll_done = 1; tick(1); poll_done = 0;
    tick(2);
    chk("R8 absent clears pass_low", pass_low, 0);
    chk("R8 absent clears fail_low", fail_low, 0);
    chk("R10 start one cycle poll", start_hi, starts);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule